// File: doc/BRIEF.md
# NAND Flash Access Timing Sequencer

This block produces the control strobes for one access to a NAND flash device. A requester presents a memory-space select, a direction, an address byte and write data. The block accepts the request only when it is idle. It then runs the access through a fixed series of timed phases and signals completion with a one-cycle done pulse.

Two memory spaces, regular and special, each have their own 32-bit timing word. The word for the selected space is sampled when the request is accepted. Its four byte-wide fields set the length of each phase.

The phases run in this order:
- Address setup, with both strobes high.
- On writes only, an interval in which the data bus is still released.
- The strobe-low wait.
- Hold, with both strobes high.

Read data is taken from the flash bus on the final strobe-low cycle.

Top module: `nand_strobe_seq`

## Requirements
- R1: During and directly after reset, `req_ready` is 1, `we_n` and `oe_n` are 1, and `data_oe` and `done` are 0.
- R2: After a request is accepted, the setup phase lasts 1 + setup-field cycles. Setup is bits 7:0 of the timing word. During setup both strobes are high and `data_oe` is low.
- R3: On a write, a bus-release phase follows setup and lasts 1 + release-field cycles. The release field is bits 31:24. During this phase both strobes are high and `data_oe` is low. A read skips this phase.
- R4: The strobe-low phase lasts 1 + wait-field cycles. The wait field is bits 15:8. During it `we_n` is low on a write and `oe_n` is low on a read. The two strobes are never low together.
- R5: The hold phase lasts N cycles, where N is the hold field (bits 23:16). A value of 0 gives 1 cycle. During hold both strobes are high. `data_oe` is high during the strobe-low and hold phases of a write, and at no other time.
- R6: After hold, `done` is high for exactly one cycle, and `req_ready` returns to 1 on the following cycle. `req_ready` is 0 for the whole access, and a `req_valid` raised during that time is ignored.
- R7: `req_space` = 0 selects the timing word `tmg_regular`, and `req_space` = 1 selects `tmg_special`.
- R8: `rd_data` takes the value of `bus_rdata` present on the last strobe-low cycle of a read. It keeps that value through later writes.
- R9: Timing words are sampled when a request is accepted. Changing them during an access does not alter that access.
- R10: `bus_addr` and `bus_wdata` carry the address and write data captured at acceptance. They stay constant until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | High when idle; request accepted when both high |
| req_space | input | 1 | 0 regular space, 1 special space |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Address byte for the access |
| req_wdata | input | DATA_W | Write data |
| tmg_regular | input | 4*FIELD_W | Regular-space timing word |
| tmg_special | input | 4*FIELD_W | Special-space timing word |
| bus_rdata | input | DATA_W | Data returned by the flash |
| we_n | output | 1 | Active-low write strobe |
| oe_n | output | 1 | Active-low output-enable strobe |
| data_oe | output | 1 | Drive enable for the write data bus |
| bus_addr | output | ADDR_W | Latched address |
| bus_wdata | output | DATA_W | Latched write data |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: a change to the timing word, and the acceptance or running of an access. The bench provokes this by scrambling both timing words on the first cycle after acceptance, while it also holds `req_valid` high with a different address. It judges the result by comparing every strobe cycle against phase lengths computed from the word that was sampled at acceptance. A second collision is the read capture on the final strobe-low cycle, which coincides with the change to hold. The bench drives fresh random read data every cycle, so only the value from that exact cycle can match.

// File: rtl/nsq_pkg.sv
package nsq_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_REL   = 3'd2,
      PH_LOW   = 3'd3,
      PH_HOLD  = 3'd4,
      PH_DONE  = 3'd5
   } phase_e;

   localparam int unsigned NSQ_NFIELDS = 4;
   localparam int unsigned NSQ_IDX_SETUP = 0;
   localparam int unsigned NSQ_IDX_WAIT  = 1;
   localparam int unsigned NSQ_IDX_HOLD  = 2;
   localparam int unsigned NSQ_IDX_REL   = 3;
endpackage

// File: rtl/nsq_timing_sel.sv
module nsq_timing_sel
   import nsq_pkg::*;
#(
   parameter int unsigned FIELD_W = 8,
   localparam int unsigned WORD_W = NSQ_NFIELDS * FIELD_W
) (
   input  logic [WORD_W-1:0]  word_a,
   input  logic [WORD_W-1:0]  word_b,
   input  logic               pick_b,
   output logic [FIELD_W-1:0] setup_x,
   output logic [FIELD_W-1:0] rel_x,
   output logic [FIELD_W-1:0] low_x,
   output logic [FIELD_W-1:0] hold_m1
);
   logic [WORD_W-1:0]  word_sel;
   logic [FIELD_W-1:0] fld [NSQ_NFIELDS];

   assign word_sel = pick_b ? word_b : word_a;

   for (genvar g = 0; g < NSQ_NFIELDS; g++) begin : g_unpack
      assign fld[g] = word_sel[g*FIELD_W +: FIELD_W];
   end

   assign setup_x = fld[NSQ_IDX_SETUP];
   assign low_x   = fld[NSQ_IDX_WAIT];
   assign rel_x   = fld[NSQ_IDX_REL];
   // reserved zero hold code is folded onto a single cycle
   assign hold_m1 = (fld[NSQ_IDX_HOLD] == '0) ? '0 : fld[NSQ_IDX_HOLD] - 1'b1;

   always_comb begin
      p_hold_fold_r5: assert (hold_m1 <= fld[NSQ_IDX_HOLD]);
   end
endmodule

// File: rtl/nsq_phase_ctrl.sv
module nsq_phase_ctrl
   import nsq_pkg::*;
#(
   parameter int unsigned FIELD_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               start_wr,
   input  logic [FIELD_W-1:0] setup_x,
   input  logic [FIELD_W-1:0] rel_x,
   input  logic [FIELD_W-1:0] low_x,
   input  logic [FIELD_W-1:0] hold_m1,
   output phase_e             phase,
   output logic               is_wr,
   output logic               last_cyc
);
   logic [FIELD_W-1:0] cnt;
   logic [FIELD_W-1:0] rel_q, low_q, hold_q;

   assign last_cyc = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         is_wr  <= 1'b0;
         rel_q  <= '0;
         low_q  <= '0;
         hold_q <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin
               phase  <= PH_SETUP;
               cnt    <= setup_x;
               is_wr  <= start_wr;
               rel_q  <= rel_x;
               low_q  <= low_x;
               hold_q <= hold_m1;
            end
            PH_SETUP: if (last_cyc) begin
               if (is_wr) begin
                  phase <= PH_REL;
                  cnt   <= rel_q;
               end else begin
                  phase <= PH_LOW;
                  cnt   <= low_q;
               end
            end else cnt <= cnt - 1'b1;
            PH_REL: if (last_cyc) begin
               phase <= PH_LOW;
               cnt   <= low_q;
            end else cnt <= cnt - 1'b1;
            PH_LOW: if (last_cyc) begin
               phase <= PH_HOLD;
               cnt   <= hold_q;
            end else cnt <= cnt - 1'b1;
            PH_HOLD: if (last_cyc) phase <= PH_DONE;
                     else cnt <= cnt - 1'b1;
            PH_DONE: phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase inside {PH_SETUP, PH_REL, PH_LOW, PH_HOLD} && cnt != '0)
      |=> (cnt == $past(cnt) - 1'b1 && phase == $past(phase)));
   p_rel_write_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_REL) |-> is_wr);
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DONE) |=> (phase == PH_IDLE));
   p_hold_to_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HOLD && cnt == '0) |=> (phase == PH_DONE));
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
   import nsq_pkg::*;
#(
   parameter int unsigned FIELD_W = 8,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 8,
   localparam int unsigned WORD_W = NSQ_NFIELDS * FIELD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_space,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [WORD_W-1:0] tmg_regular,
   input  logic [WORD_W-1:0] tmg_special,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              we_n,
   output logic              oe_n,
   output logic              data_oe,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              done
);
   initial begin
      p_field_width: assert (FIELD_W >= 2 && ADDR_W >= 1 && DATA_W >= 1);
   end

   phase_e             phase;
   logic               is_wr, last_cyc, accept;
   logic [FIELD_W-1:0] setup_x, rel_x, low_x, hold_m1;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid & req_ready;

   nsq_timing_sel #(.FIELD_W(FIELD_W)) i_sel (
      .word_a  (tmg_regular),
      .word_b  (tmg_special),
      .pick_b  (req_space),
      .setup_x (setup_x),
      .rel_x   (rel_x),
      .low_x   (low_x),
      .hold_m1 (hold_m1)
   );

   nsq_phase_ctrl #(.FIELD_W(FIELD_W)) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .start_wr (req_write),
      .setup_x  (setup_x),
      .rel_x    (rel_x),
      .low_x    (low_x),
      .hold_m1  (hold_m1),
      .phase    (phase),
      .is_wr    (is_wr),
      .last_cyc (last_cyc)
   );

   assign we_n    = !(phase == PH_LOW &&  is_wr);
   assign oe_n    = !(phase == PH_LOW && !is_wr);
   assign data_oe = is_wr && (phase == PH_LOW || phase == PH_HOLD);
   assign done    = (phase == PH_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_addr  <= '0;
         bus_wdata <= '0;
         rd_data   <= '0;
      end else begin
         if (accept) begin
            bus_addr  <= req_addr;
            bus_wdata <= req_wdata;
         end
         if (phase == PH_LOW && !is_wr && last_cyc) rd_data <= bus_rdata;
      end
   end

   p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !oe_n));
   p_doe_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> oe_n);
   p_ready_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> req_ready);
   p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> ($stable(bus_addr) && $stable(bus_wdata)));
   p_rd_only_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr || req_ready) |=> $stable(rd_data));
endmodule

// File: tb/test_nand_strobe_seq.sv
`timescale 1ns/1ps
module test_nand_strobe_seq;
   localparam int FW = 8;
   localparam int AW = 8;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_space = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [4*FW-1:0] tmg_regular = 32'hFCFCFCFC;
   logic [4*FW-1:0] tmg_special = 32'hFCFCFCFC;
   logic [DW-1:0] bus_rdata = '0;
   logic          we_n, oe_n, data_oe, done;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, rd_data;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   logic [DW-1:0] last_rd = '0;

   always #2 clk = ~clk;

   nand_strobe_seq #(.FIELD_W(FW), .ADDR_W(AW), .DATA_W(DW)) i_nand_strobe_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_space(req_space), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .tmg_regular(tmg_regular), .tmg_special(tmg_special),
      .bus_rdata(bus_rdata), .we_n(we_n), .oe_n(oe_n), .data_oe(data_oe),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data), .done(done)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // one access; caller is at a negedge with the block idle
   task automatic do_access(input bit sp, input bit wr, input logic [AW-1:0] a,
                            input logic [DW-1:0] wd, input logic [31:0] wreg,
                            input logic [31:0] wspc, input bit scramble);
      logic [31:0] w;
      int st, hz, wt, ht, S, H, W, D, T, k;
      logic [4:0] exp_v, act_v;
      logic [DW-1:0] exp_rd;
      string tag;
      tmg_regular = wreg;
      tmg_special = wspc;
      w  = sp ? wspc : wreg;
      st = int'(w[7:0]);  wt = int'(w[15:8]);
      ht = int'(w[23:16]); hz = int'(w[31:24]);
      S = 1 + st; H = wr ? 1 + hz : 0; W = 1 + wt; D = (ht == 0) ? 1 : ht;
      T = S + H + W + D;
      exp_rd = last_rd;
      req_valid = 1'b1; req_space = sp; req_write = wr; req_addr = a; req_wdata = wd;
      @(posedge clk);
      for (k = 0; k <= T; k++) begin
         @(negedge clk);
         if (k == 0) begin
            if (scramble) begin   // R9: timing words change mid-access
               tmg_regular = $urandom;
               tmg_special = $urandom;
               req_addr  = ~a;
               req_wdata = ~wd;
               req_space = ~sp;
               req_write = ~wr;
            end else req_valid = 1'b0;
         end
         if (k < S)                begin exp_v = 5'b01100; tag = "R2 setup"; end
         else if (k < S + H)       begin exp_v = 5'b01100; tag = "R3 release"; end
         else if (k < S + H + W)   begin exp_v = {1'b0, ~wr, wr, wr, 1'b0}; tag = "R4 strobe-low"; end
         else if (k < T)           begin exp_v = {1'b0, 1'b1, 1'b1, wr, 1'b0}; tag = "R5 hold"; end
         else                      begin exp_v = 5'b01101; tag = "R6 done"; end
         act_v = {req_ready, we_n, oe_n, data_oe, done};
         chk(act_v == exp_v, scramble ? {tag, " R9"} : {tag, sp ? " R7 special" : " R7 regular"},
             32'(act_v), 32'(exp_v));
         chk(bus_addr == a && bus_wdata == wd, "R10 addr/wdata held",
             {16'h0, bus_addr, bus_wdata}, {16'h0, a, wd});
         bus_rdata = DW'($urandom);
         if (!wr && k == S + H + W - 1) exp_rd = bus_rdata;
         if (k == T) req_valid = 1'b0;
      end
      @(negedge clk);
      chk(req_ready == 1'b1 && done == 1'b0, "R6 ready after done",
          {30'h0, req_ready, done}, 32'h2);
      chk(rd_data == exp_rd, wr ? "R8 rd_data unchanged by write" : "R8 read capture",
          32'(rd_data), 32'(exp_rd));
      last_rd = exp_rd;
   endtask

   function automatic logic [31:0] rnd_word();
      logic [31:0] r;
      r = $urandom;
      return {5'b0, r[26:24], 5'b0, r[18:16], 5'b0, r[10:8], 5'b0, r[2:0]};
   endfunction

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      chk({req_ready, we_n, oe_n, data_oe, done} == 5'b11100, "R1 in reset",
          32'({req_ready, we_n, oe_n, data_oe, done}), 32'h1C);
      rst_n = 1'b1;
      @(negedge clk);
      chk({req_ready, we_n, oe_n, data_oe, done} == 5'b11100, "R1 after reset",
          32'({req_ready, we_n, oe_n, data_oe, done}), 32'h1C);

      // directed corners
      do_access(1'b0, 1'b1, 8'h11, 8'hA5, 32'h00000000, 32'h03030303, 1'b0); // R5 hold 0 -> 1
      do_access(1'b0, 1'b0, 8'h22, 8'h00, 32'h00000000, 32'h03030303, 1'b0);
      do_access(1'b1, 1'b1, 8'h33, 8'h5A, 32'h00000000, 32'h02050104, 1'b0); // R7 special
      do_access(1'b1, 1'b0, 8'h44, 8'h00, 32'h01010101, 32'h04010302, 1'b0); // R3 read skips release
      do_access(1'b0, 1'b1, 8'h55, 8'h66, 32'h00000000, 32'h00000000, 1'b0); // R8 write keeps rd_data
      do_access(1'b0, 1'b0, 8'h77, 8'h00, 32'hFFFFFFFF, 32'h00000000, 1'b0); // max fields
      do_access(1'b1, 1'b1, 8'h88, 8'h99, 32'h00000000, 32'hFCFCFCFC, 1'b1); // reset-default word, R9
      do_access(1'b0, 1'b0, 8'hAB, 8'h00, 32'h02010002, 32'h00000000, 1'b1);

      for (int i = 0; i < 60; i++) begin
         do_access(1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom),
                   rnd_word(), rnd_word(), 1'($urandom));
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule